// File: doc/BRIEF.md
# Speculative Address Alias-Check Bank

This block is one bank of an alias detector that software steers during memory speculation. It keeps a short list of hashed word addresses, each marked live or retired. Each speculative memory operation presented to the bank does one of two things. It either records its hashed address in the next free slot, or it compares its hashed address against every live slot in the same cycle. A match raises a rollback pulse on the following cycle, so the core can re-run the speculated code.

A clear command retires every slot at once and resets the fill position. Two saturating counters track the bank's history: how many times it was cleared (uses) and how many rollbacks it raised (failures). When software binds the bank to a new speculation group, it loads both counters through the initialization port. The hash drops the two byte-offset bits of the 32-bit address and XOR-folds the remaining 30 bits into 12 bits. Slots hold no data.

Top module: `alias_bank`

## Requirements
- R1: The 12-bit hash of an address `a` is `a[13:2] ^ a[25:14] ^ {6'b0, a[31:26]}`. Address bits [1:0] never affect a match.
- R2: A push (`op_valid`=1, `op_add`=1, `clr`=0) stores the hash in the next free slot, in slot order 0 to 7, and marks that slot live. A push never raises `rollback`.
- R3: A check (`op_valid`=1, `op_add`=0) whose hash equals any live slot drives `rollback` high in the cycle after the check, for exactly one cycle per check. Without such a match, `rollback` stays low.
- R4: `clr`=1 marks all slots retired, so later checks match nothing until new pushes arrive. It also returns the fill position to slot 0 and lowers `full` and `overflow` in the next cycle.
- R5: A check issued in the same cycle as `clr` is judged against the slots as they were before the clear. A push issued in the same cycle as `clr` is discarded.
- R6: `full` is high while all 8 slots hold pushes since the last clear. A push while `full` is high stores nothing and sets `overflow`, which stays high until the next `clr`.
- R7: `use_count` rises by one on each `clr`. `fail_count` rises by one on each check that matches, and becomes visible in the same cycle as the corresponding `rollback` pulse.
- R8: Both counters are 16 bits wide and stop at 0xFFFF instead of wrapping.
- R9: `init_valid`=1 loads `init_uses` into `use_count` and `init_fails` into `fail_count` on the next edge. The load takes precedence over any increment in that same cycle.
- R10: After a synchronous reset, `rollback`, `full` and `overflow` are 0, both counters are 0 and all slots are retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A speculative memory operation is present this cycle |
| op_add | input | 1 | 1: record the address; 0: check the address |
| op_addr | input | 32 | Byte address of the operation |
| clr | input | 1 | Retire all slots and count one use |
| init_valid | input | 1 | Load both counters from the init values |
| init_uses | input | 16 | Value loaded into the use counter |
| init_fails | input | 16 | Value loaded into the failure counter |
| rollback | output | 1 | One-cycle alias pulse, one cycle after a matching check |
| use_count | output | 16 | Saturating count of clears |
| fail_count | output | 16 | Saturating count of rollbacks |
| full | output | 1 | All slots filled since the last clear |
| overflow | output | 1 | Sticky: a push was dropped because the bank was full |

## Verification
The assertions assume that the inputs are known, two-state values whenever reset is low. They also assume that `op_add` is meaningful only while `op_valid` is high. They place no limit on how `clr`, `init_valid` and operations combine in one cycle, because the design defines a priority for every such combination. The stimulus always drives every input from a defined value. It deliberately overlaps `clr` with a check, with a push, and with a counter load, so the priority rules are exercised rather than avoided.

// File: rtl/alias_bank_pkg.sv
package alias_bank_pkg;

    localparam int ADDR_W  = 32;
    localparam int OFS_W   = 2;
    localparam int HASH_W  = 12;
    localparam int DEPTH   = 8;
    localparam int PTR_W   = $clog2(DEPTH + 1);
    localparam int CNT_W   = 16;
    localparam int WORD_W  = ADDR_W - OFS_W;
    localparam int NCHUNK  = (WORD_W + HASH_W - 1) / HASH_W;

    typedef logic [HASH_W-1:0] hash_t;
    typedef logic [CNT_W-1:0]  count_t;

    typedef struct packed {
        logic  live;
        hash_t tag;
    } slot_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_PROBE = 2'd2
    } op_kind_e;

    function automatic op_kind_e decode_op(input logic valid, input logic add);
        if (!valid)
            return OP_IDLE;
        return add ? OP_PUSH : OP_PROBE;
    endfunction

endpackage

// File: rtl/alias_hash.sv
module alias_hash
    import alias_bank_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int OW = OFS_W,
    parameter int HW = HASH_W
) (
    input  logic [AW-1:0] addr_i,
    output logic [HW-1:0] hash_o
);
    localparam int WW = AW - OW;
    localparam int NC = (WW + HW - 1) / HW;

    logic [NC*HW-1:0] padded;
    logic [HW-1:0]    partial [NC+1];

    always_comb begin
        padded         = '0;
        padded[WW-1:0] = addr_i[AW-1:OW];
    end

    assign partial[0] = '0;

    for (genvar c = 0; c < NC; c++) begin : g_fold
        assign partial[c+1] = partial[c] ^ padded[c*HW +: HW];
    end

    assign hash_o = partial[NC];

endmodule

// File: rtl/alias_slots.sv
module alias_slots
    import alias_bank_pkg::*;
#(
    parameter int N  = DEPTH,
    parameter int PW = $clog2(N + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  op_kind_e op_i,
    input  hash_t    hash_i,
    input  logic     clr_i,
    output logic     hit_o,
    output logic     full_o,
    output logic     overflow_o
);
    slot_t          slots [N];
    logic [PW-1:0]  wr_ptr;
    logic [N-1:0]   match;
    logic           push_req;
    logic           push_ok;
    logic           is_full;

    assign is_full  = (wr_ptr == PW'(N));
    assign push_req = (op_i == OP_PUSH) && !clr_i;
    assign push_ok  = push_req && !is_full;

    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slots[i] <= '0;
            else if (clr_i)
                slots[i].live <= 1'b0;
            else if (push_ok && wr_ptr == PW'(i))
                slots[i] <= '{live: 1'b1, tag: hash_i};
        end
        assign match[i] = slots[i].live && (slots[i].tag == hash_i);
    end

    assign hit_o = (op_i == OP_PROBE) && (|match);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            overflow_o <= 1'b0;
        end else if (clr_i) begin
            wr_ptr     <= '0;
            overflow_o <= 1'b0;
        end else begin
            if (push_ok)
                wr_ptr <= wr_ptr + 1'b1;
            if (push_req && is_full)
                overflow_o <= 1'b1;
        end
    end

    assign full_o = is_full;

    // R4
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (!full_o && !overflow_o));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overflow_o && !clr_i) |=> overflow_o);

    // R6
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ptr <= PW'(N));

    // R6
    ovf_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow_o) |-> $past(full_o));

endmodule

// File: rtl/sat_counter.sv
module sat_counter
    import alias_bank_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_o <= '0;
        else if (load_i)
            cnt_o <= load_val_i;
        else if (inc_i && cnt_o != TOP)
            cnt_o <= cnt_o + 1'b1;
    end

    // R9
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> cnt_o == $past(load_val_i));

    // R8
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_o == TOP) |=> cnt_o == TOP);

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !inc_i) |=> $stable(cnt_o));

endmodule

// File: rtl/alias_bank.sv
module alias_bank
    import alias_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_add,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              clr,
    input  logic              init_valid,
    input  logic [CNT_W-1:0]  init_uses,
    input  logic [CNT_W-1:0]  init_fails,
    output logic              rollback,
    output logic [CNT_W-1:0]  use_count,
    output logic [CNT_W-1:0]  fail_count,
    output logic              full,
    output logic              overflow
);
    op_kind_e op_kind;
    hash_t    op_hash;
    logic     hit;

    assign op_kind = decode_op(op_valid, op_add);

    alias_hash #(.AW(ADDR_W), .OW(OFS_W), .HW(HASH_W)) u_hash (
        .addr_i (op_addr),
        .hash_o (op_hash)
    );

    alias_slots #(.N(DEPTH), .PW(PTR_W)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .op_i       (op_kind),
        .hash_i     (op_hash),
        .clr_i      (clr),
        .hit_o      (hit),
        .full_o     (full),
        .overflow_o (overflow)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rollback <= 1'b0;
        else
            rollback <= hit;
    end

    sat_counter #(.W(CNT_W)) u_uses (
        .clk        (clk),
        .rst        (rst),
        .load_i     (init_valid),
        .load_val_i (init_uses),
        .inc_i      (clr),
        .cnt_o      (use_count)
    );

    sat_counter #(.W(CNT_W)) u_fails (
        .clk        (clk),
        .rst        (rst),
        .load_i     (init_valid),
        .load_val_i (init_fails),
        .inc_i      (hit),
        .cnt_o      (fail_count)
    );

    // R3
    rollback_src_chk: assert property (@(posedge clk) disable iff (rst)
        rollback |-> $past(op_valid && !op_add));

    // R2
    push_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_add) |=> !rollback);

    // R7
    fail_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rollback && !$past(init_valid) && $past(fail_count) != '1)
            |-> fail_count == $past(fail_count) + 1'b1);

endmodule

// File: tb/alias_bank_tb.sv
module alias_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    // {op_valid, op_add, clr, addr[31:0], expected rollback}
    localparam logic [35:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 1'b0, 32'h0000_0010, 1'b0},
        {1'b1, 1'b0, 1'b0, 32'h0000_0020, 1'b0},
        {1'b1, 1'b0, 1'b0, 32'h0000_0013, 1'b1},
        {1'b1, 1'b0, 1'b0, 32'h0000_4014, 1'b1},
        {1'b1, 1'b0, 1'b0, 32'h0400_0014, 1'b1},
        {1'b1, 1'b1, 1'b0, 32'h0000_0100, 1'b0},
        {1'b1, 1'b0, 1'b0, 32'h0000_0100, 1'b1},
        {1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b0},
        {1'b1, 1'b0, 1'b0, 32'h0000_0010, 1'b0},
        {1'b1, 1'b1, 1'b0, 32'h0000_0010, 1'b0},
        {1'b1, 1'b0, 1'b0, 32'h0000_0010, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, op_add, clr, init_valid;
    logic [31:0] op_addr;
    logic [15:0] init_uses, init_fails;
    logic        rollback, full, overflow;
    logic [15:0] use_count, fail_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int exp_uses  = 0;
    int exp_fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alias_bank u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_add(op_add),
        .op_addr(op_addr), .clr(clr), .init_valid(init_valid),
        .init_uses(init_uses), .init_fails(init_fails),
        .rollback(rollback), .use_count(use_count), .fail_count(fail_count),
        .full(full), .overflow(overflow)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic a, input logic c,
                       input logic [31:0] addr);
        op_valid = v; op_add = a; clr = c; op_addr = addr;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; op_add = 1'b0; clr = 1'b0; init_valid = 1'b0;
        op_addr = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_valid = 0; op_add = 0; clr = 0; init_valid = 0;
        op_addr = '0; init_uses = '0; init_fails = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        check("R10 rollback", {31'b0, rollback}, 0);
        check("R10 use_count", {16'b0, use_count}, 0);
        check("R10 fail_count", {16'b0, fail_count}, 0);
        check("R10 full", {31'b0, full}, 0);
        check("R10 overflow", {31'b0, overflow}, 0);

        // Vector table: R1 hash folding, R2 push, R3 match, R4 clear
        for (int i = 0; i < NVEC; i++) begin
            logic [35:0] v;
            v = VEC[i];
            cyc(v[35], v[34], v[33], v[32:1]);
            if (v[33]) exp_uses++;
            if (v[0]) exp_fails++;
            check($sformatf("R1/R2/R3/R4 vec%0d rollback", i), {31'b0, rollback}, {31'b0, v[0]});
        end
        check("R7 use_count after table", {16'b0, use_count}, exp_uses);
        check("R7 fail_count after table", {16'b0, fail_count}, exp_fails);

        // R3 single-cycle pulse
        cyc(1'b0, 1'b0, 1'b0, 32'h0);
        check("R3 pulse drops", {31'b0, rollback}, 0);

        // R6 fill and overflow
        cyc(1'b0, 1'b0, 1'b1, 32'h0); exp_uses++;
        for (int i = 0; i < 8; i++) begin
            cyc(1'b1, 1'b1, 1'b0, 32'h1000 + i*4);
            check($sformatf("R6 full after %0d pushes", i+1), {31'b0, full}, (i == 7) ? 1 : 0);
        end
        check("R6 overflow before extra push", {31'b0, overflow}, 0);
        cyc(1'b1, 1'b1, 1'b0, 32'h0000_0900);
        check("R6 overflow set", {31'b0, overflow}, 1);
        cyc(1'b1, 1'b0, 1'b0, 32'h0000_0900);
        check("R6 dropped push not stored", {31'b0, rollback}, 0);
        check("R6 overflow sticky", {31'b0, overflow}, 1);
        cyc(1'b1, 1'b0, 1'b0, 32'h0000_101C); exp_fails++;
        check("R2 eighth slot matches", {31'b0, rollback}, 1);
        cyc(1'b0, 1'b0, 1'b1, 32'h0); exp_uses++;
        check("R4 full cleared", {31'b0, full}, 0);
        check("R4 overflow cleared", {31'b0, overflow}, 0);

        // R5 check together with clear sees old state
        cyc(1'b1, 1'b1, 1'b0, 32'h0000_2000);
        cyc(1'b1, 1'b0, 1'b1, 32'h0000_2000); exp_uses++; exp_fails++;
        check("R5 check with clr matches", {31'b0, rollback}, 1);
        cyc(1'b1, 1'b0, 1'b0, 32'h0000_2000);
        check("R4 retired after clr", {31'b0, rollback}, 0);

        // R5 push together with clear is dropped
        cyc(1'b1, 1'b1, 1'b1, 32'h0000_3000); exp_uses++;
        cyc(1'b1, 1'b0, 1'b0, 32'h0000_3000);
        check("R5 push with clr dropped", {31'b0, rollback}, 0);
        check("R7 use_count", {16'b0, use_count}, exp_uses);
        check("R7 fail_count", {16'b0, fail_count}, exp_fails);

        // R9 load, R8 saturation
        init_uses = 16'hFFFE; init_fails = 16'hFFFE; init_valid = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 32'h0);
        check("R9 use load", {16'b0, use_count}, 32'hFFFE);
        check("R9 fail load", {16'b0, fail_count}, 32'hFFFE);
        cyc(1'b0, 1'b0, 1'b1, 32'h0);
        cyc(1'b0, 1'b0, 1'b1, 32'h0);
        check("R8 use saturates", {16'b0, use_count}, 32'hFFFF);
        cyc(1'b1, 1'b1, 1'b0, 32'h0000_0010);
        cyc(1'b1, 1'b0, 1'b0, 32'h0000_0010);
        cyc(1'b1, 1'b0, 1'b0, 32'h0000_0010);
        check("R3 rollback at saturation", {31'b0, rollback}, 1);
        check("R8 fail saturates", {16'b0, fail_count}, 32'hFFFF);

        // R9 load wins over clr increment
        init_uses = 16'h0003; init_fails = 16'h0007; init_valid = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, 32'h0);
        check("R9 load beats clr", {16'b0, use_count}, 3);
        check("R9 fail loaded", {16'b0, fail_count}, 7);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule